// File: doc/BRIEF.md
# Paging Receiver Mode Sequencer

This block is the operating-mode controller of a paging decoder that receives batched codewords. It has three modes: idle waiting, a preamble hunt, and batch reception. It watches a bit strobe and two detection pulses that come from pattern detectors outside the block. One pulse marks a preamble pattern and the other marks a synchronisation codeword. The block tracks where the receiver sits inside a batch. It drives three battery-saving lines that gate the radio front end, and a flag that reports whether sync is held.

A batch is one sync slot followed by sixteen codeword slots. The block reports the current slot, with the sync slot numbered 16. It also raises a frame-enable output that tells the address matcher when the receiver's own frame is on air. The own frame is chosen by a configuration input. The serial bit stream is offered through a valid strobe. The block takes every strobed bit in the cycle it is offered and never applies back-pressure, so it has no ready output. The upstream logic may leave gaps of any length between strobes.

Top module: `pgr_mode_seq`

## Requirements
- R1: From waiting mode (mode code 2'b00), a `pre_det` pulse moves the block to preamble mode (code 2'b01) on the next clock edge. Strobed bits and `sync_det` pulses leave waiting mode unchanged.
- R2: Throughout preamble mode the battery-save lines read bs1=1, bs2=0, bs3=1.
- R3: A `sync_det` pulse in preamble mode moves the block to receiving mode (code 2'b10). The slot starts at 0 with a fresh bit count, and `sync_ok` reads 1.
- R4: Preamble mode returns to waiting when the 544th strobed bit arrives without sync. A `sync_det` that arrives in the same cycle as that bit still wins and enters receiving mode.
- R5: In receiving mode every 32 strobed bits advance the slot by one, through 0..15 and then 16 (the sync slot), and slot 16 wraps to 0. Cycles without `bit_valid` do not advance anything.
- R6: At the end of slot 16, `sync_ok` becomes 1 if `sync_det` pulsed during that slot and 0 if it did not.
- R7: Two consecutive batches whose sync slot ends without sync return the block to waiting mode. A batch with sync found clears the miss count.
- R8: `own_frame` is high exactly in receiving mode while the slot equals 2F or 2F+1, where F is `self_frame`.
- R9: In receiving mode, `msg_rx` high gives bs=1,0,1. Otherwise `own_frame` or the sync slot gives bs=1,1,1, and any other slot gives bs=0,0,0.
- R10: `pre_det` pulses outside waiting mode have no effect. In particular they do not restart the preamble window.
- R11: A synchronous active-high `rst` gives waiting mode, slot 0, `sync_ok`=0, `own_frame`=0 and all battery-save lines low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | One received bit offered this cycle; always accepted |
| pre_det | input | 1 | Pulse: preamble pattern detected |
| sync_det | input | 1 | Pulse: sync codeword detected |
| msg_rx | input | 1 | Message data is being received after an address match |
| self_frame | input | 3 | Frame number assigned to this receiver |
| mode | output | 2 | 00 waiting, 01 preamble, 10 receiving |
| slot | output | 5 | Batch slot: 0..15 codewords, 16 sync |
| own_frame | output | 1 | Enable for the address matcher over the own frame |
| sync_ok | output | 1 | Sync held at the last batch boundary |
| bs1 | output | 1 | Battery-save line 1 |
| bs2 | output | 1 | Battery-save line 2 |
| bs3 | output | 1 | Battery-save line 3 |

## Verification
The bench builds the block with its default parameters: 32-bit slots, sixteen codewords per batch, a 544-bit preamble window and a miss limit of two. A full batch is only 544 strobes, so the test reaches the exact expiry of the preamble window, the tie between expiry and sync on one strobe, and the wrap from slot 16 to 0 in a few thousand cycles. It also covers a miss, hit, miss, miss sequence of sync results and own-frame windows at frames 3 and 0.

// File: rtl/pgr_pkg.sv
package pgr_pkg;
  typedef enum logic [1:0] {
    MODE_WAIT = 2'b00,
    MODE_PRE  = 2'b01,
    MODE_RX   = 2'b10
  } pgr_mode_e;
endpackage

// File: rtl/pgr_slot_tmr.sv
// Bit and slot counter for receiving mode; cleared whenever not running.
module pgr_slot_tmr #(
  parameter int SLOT_BITS = 32,
  parameter int NUM_CW    = 16,
  parameter int SLOT_W    = $clog2(NUM_CW + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              bit_valid,
  output logic [SLOT_W-1:0] slot,
  output logic              batch_end
);
  localparam int BIT_W = $clog2(SLOT_BITS);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
  localparam logic [SLOT_W-1:0] SYNC_SLOT = SLOT_W'(NUM_CW);

  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_done;

  assign slot_done = run && bit_valid && (bit_q == LAST_BIT);
  assign batch_end = slot_done && (slot_q == SYNC_SLOT);
  assign slot      = slot_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (bit_valid) begin
      if (slot_done) begin
        bit_q  <= '0;
        slot_q <= (slot_q == SYNC_SLOT) ? '0 : slot_q + SLOT_W'(1);
      end else begin
        bit_q <= bit_q + BIT_W'(1);
      end
    end
  end
endmodule

// File: rtl/pgr_pre_win.sv
// Preamble search window: counts strobed bits while running.
module pgr_pre_win #(
  parameter int WIN_BITS = 544
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic bit_valid,
  output logic expire
);
  localparam int CNT_W = $clog2(WIN_BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIN_BITS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && bit_valid && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (bit_valid && !expire) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pgr_sync_mon.sv
// Tracks sync presence per batch and counts consecutive misses.
module pgr_sync_mon #(
  parameter int MISS_LIMIT = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic in_rx,
  input  logic in_sync_slot,
  input  logic sync_det,
  input  logic batch_end,
  output logic sync_ok,
  output logic lost
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

  logic              seen_q;
  logic              ok_q;
  logic [MISS_W-1:0] miss_q;
  logic              seen_now;

  assign seen_now = seen_q || (in_sync_slot && sync_det);
  assign lost     = in_rx && batch_end && !seen_now && (miss_q == MISS_LAST);
  assign sync_ok  = ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
      miss_q <= '0;
    end else if (arm) begin
      seen_q <= 1'b0;
      ok_q   <= 1'b1;
      miss_q <= '0;
    end else if (!in_rx) begin
      seen_q <= 1'b0;
      ok_q   <= 1'b0;
      miss_q <= '0;
    end else if (batch_end) begin
      seen_q <= 1'b0;
      ok_q   <= seen_now;
      miss_q <= seen_now ? '0 : miss_q + MISS_W'(1);
    end else if (in_sync_slot && sync_det) begin
      seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pgr_bs_dec.sv
// Battery-save level decode from mode and slot context.
module pgr_bs_dec
  import pgr_pkg::*;
(
  input  pgr_mode_e mode,
  input  logic      in_sync_slot,
  input  logic      own_frame,
  input  logic      msg_rx,
  output logic      bs1,
  output logic      bs2,
  output logic      bs3
);
  always_comb begin
    {bs1, bs2, bs3} = 3'b000;
    case (mode)
      MODE_PRE: {bs1, bs2, bs3} = 3'b101;
      MODE_RX: begin
        if (msg_rx)                         {bs1, bs2, bs3} = 3'b101;
        else if (own_frame || in_sync_slot) {bs1, bs2, bs3} = 3'b111;
        else                                {bs1, bs2, bs3} = 3'b000;
      end
      default: {bs1, bs2, bs3} = 3'b000;
    endcase
  end
endmodule

// File: rtl/pgr_mode_seq.sv
// Top: operating-mode sequencer of the paging receiver.
module pgr_mode_seq
  import pgr_pkg::*;
#(
  parameter int SLOT_BITS  = 32,
  parameter int NUM_CW     = 16,
  parameter int WIN_BITS   = 544,
  parameter int MISS_LIMIT = 2,
  parameter int FRAME_W    = $clog2(NUM_CW / 2),
  parameter int SLOT_W     = $clog2(NUM_CW + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bit_valid,
  input  logic               pre_det,
  input  logic               sync_det,
  input  logic               msg_rx,
  input  logic [FRAME_W-1:0] self_frame,
  output logic [1:0]         mode,
  output logic [SLOT_W-1:0]  slot,
  output logic               own_frame,
  output logic               sync_ok,
  output logic               bs1,
  output logic               bs2,
  output logic               bs3
);
  localparam logic [SLOT_W-1:0] SYNC_SLOT = SLOT_W'(NUM_CW);

  pgr_mode_e         mode_q;
  logic              in_pre, in_rx, in_sync_slot;
  logic              win_expire, batch_end, lost, arm;
  logic [SLOT_W-1:0] own_base;

  assign in_pre       = (mode_q == MODE_PRE);
  assign in_rx        = (mode_q == MODE_RX);
  assign in_sync_slot = in_rx && (slot == SYNC_SLOT);
  assign arm          = in_pre && sync_det;
  assign own_base     = SLOT_W'({self_frame, 1'b0});
  assign own_frame    = in_rx && ((slot == own_base) || (slot == own_base + SLOT_W'(1)));
  assign mode         = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_WAIT;
    end else begin
      case (mode_q)
        MODE_WAIT: if (pre_det) mode_q <= MODE_PRE;
        MODE_PRE: begin
          if (sync_det)        mode_q <= MODE_RX;
          else if (win_expire) mode_q <= MODE_WAIT;
        end
        MODE_RX:   if (lost) mode_q <= MODE_WAIT;
        default:   mode_q <= MODE_WAIT;
      endcase
    end
  end

  pgr_pre_win #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst(rst), .run(in_pre), .bit_valid(bit_valid), .expire(win_expire)
  );

  pgr_slot_tmr #(.SLOT_BITS(SLOT_BITS), .NUM_CW(NUM_CW), .SLOT_W(SLOT_W)) u_tmr (
    .clk(clk), .rst(rst), .run(in_rx), .bit_valid(bit_valid),
    .slot(slot), .batch_end(batch_end)
  );

  pgr_sync_mon #(.MISS_LIMIT(MISS_LIMIT)) u_sync (
    .clk(clk), .rst(rst), .arm(arm), .in_rx(in_rx), .in_sync_slot(in_sync_slot),
    .sync_det(sync_det), .batch_end(batch_end), .sync_ok(sync_ok), .lost(lost)
  );

  pgr_bs_dec u_bs (
    .mode(mode_q), .in_sync_slot(in_sync_slot), .own_frame(own_frame),
    .msg_rx(msg_rx), .bs1(bs1), .bs2(bs2), .bs3(bs3)
  );
endmodule

// File: rtl/pgr_mode_seq_chk.sv
// Property checker attached to the sequencer top.
module pgr_mode_seq_chk #(
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [SLOT_W-1:0] slot,
  input logic              own_frame,
  input logic              sync_ok,
  input logic              msg_rx,
  input logic              bs1,
  input logic              bs2,
  input logic              bs3
);
  a_r11_reset_state: assert property (@(posedge clk)
    rst |=> (mode == 2'b00 && {bs1, bs2, bs3} == 3'b000 && !sync_ok));

  a_r1_wait_exit: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (mode == 2'b00 || mode == 2'b01));

  a_r2_pre_levels: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |-> ({bs1, bs2, bs3} == 3'b101));

  a_r3_rx_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01) |=> (mode != 2'b10 || (slot == '0 && sync_ok)));

  a_r5_slot_range: assert property (@(posedge clk) disable iff (rst)
    slot <= SLOT_W'(16));

  a_r5_slot_step: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && $past(mode) == 2'b10 && slot != $past(slot)) |->
      (($past(slot) == SLOT_W'(16)) ? (slot == '0) : (slot == $past(slot) + SLOT_W'(1))));

  a_r8_own_in_rx: assert property (@(posedge clk) disable iff (rst)
    own_frame |-> (mode == 2'b10 && slot < SLOT_W'(16)));

  a_r9_quiet_slot: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !msg_rx && !own_frame && slot != SLOT_W'(16)) |->
      ({bs1, bs2, bs3} == 3'b000));

  a_r9_msg_levels: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && msg_rx) |-> ({bs1, bs2, bs3} == 3'b101));
endmodule

bind pgr_mode_seq pgr_mode_seq_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .slot(slot), .own_frame(own_frame),
  .sync_ok(sync_ok), .msg_rx(msg_rx), .bs1(bs1), .bs2(bs2), .bs3(bs3)
);

// File: tb/pgr_mode_seq_test.sv
module pgr_mode_seq_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_valid = 1'b0;
  logic       pre_det = 1'b0;
  logic       sync_det = 1'b0;
  logic       msg_rx = 1'b0;
  logic [2:0] self_frame = 3'd3;
  logic [1:0] mode;
  logic [4:0] slot;
  logic       own_frame, sync_ok, bs1, bs2, bs3;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pgr_mode_seq uut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .pre_det(pre_det),
    .sync_det(sync_det), .msg_rx(msg_rx), .self_frame(self_frame),
    .mode(mode), .slot(slot), .own_frame(own_frame), .sync_ok(sync_ok),
    .bs1(bs1), .bs2(bs2), .bs3(bs3)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(int n);
    bit_valid = 1'b1;
    repeat (n) tick();
    bit_valid = 1'b0;
  endtask

  task automatic pulse_pre();
    pre_det = 1'b1; tick(); pre_det = 1'b0;
  endtask

  task automatic pulse_sync();
    sync_det = 1'b1; tick(); sync_det = 1'b0;
  endtask

  function automatic int bsv();
    return int'({bs1, bs2, bs3});
  endfunction

  task automatic t_reset();
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    check("R11 mode", mode, 0);
    check("R11 bs", bsv(), 0);
    check("R11 sync_ok", sync_ok, 0);
    check("R11 own_frame", own_frame, 0);
    check("R11 slot", slot, 0);
  endtask

  task automatic t_wait_ignore();
    pulse_sync();
    check("R1 sync ignored in wait", mode, 0);
    feed(600);
    check("R1 bits ignored in wait", mode, 0);
  endtask

  task automatic t_pre_expire();
    pulse_pre();
    check("R1 enter preamble", mode, 1);
    check("R2 preamble bs levels", bsv(), 5);
    feed(300);
    pulse_pre();
    check("R10 pre_det in preamble", mode, 1);
    feed(243);
    check("R4 still preamble at 543 bits", mode, 1);
    check("R2 bs held in preamble", bsv(), 5);
    feed(1);
    check("R4 window expiry", mode, 0);
    check("R4 bs after expiry", bsv(), 0);
  endtask

  task automatic t_pre_tie();
    pulse_pre();
    feed(543);
    bit_valid = 1'b1; sync_det = 1'b1; tick();
    bit_valid = 1'b0; sync_det = 1'b0;
    check("R4 sync wins on last bit", mode, 2);
    check("R3 entry slot", slot, 0);
    check("R3 entry sync_ok", sync_ok, 1);
  endtask

  task automatic t_slots_sync();
    feed(31);
    check("R5 slot after 31 bits", slot, 0);
    repeat (5) tick();
    check("R5 no advance without strobe", slot, 0);
    feed(1);
    check("R5 slot after 32 bits", slot, 1);
    feed(32 * 14);
    check("R5 slot 15", slot, 15);
    feed(32);
    check("R5 sync slot 16", slot, 16);
    feed(32);
    check("R5 wrap to 0", slot, 0);
    check("R6 miss clears sync_ok", sync_ok, 0);
    check("R7 one miss stays rx", mode, 2);
    feed(32 * 16);
    pulse_sync();
    feed(32);
    check("R6 hit sets sync_ok", sync_ok, 1);
    check("R7 rx after hit", mode, 2);
    feed(544);
    check("R7 miss after hit stays rx", mode, 2);
    check("R6 miss after hit", sync_ok, 0);
    feed(544);
    check("R7 second miss to wait", mode, 0);
    check("R7 bs low in wait", bsv(), 0);
    check("R7 sync_ok low in wait", sync_ok, 0);
  endtask

  task automatic t_own_frame();
    self_frame = 3'd3;
    msg_rx = 1'b0;
    pulse_pre();
    pulse_sync();
    check("R3 rx entered", mode, 2);
    check("R9 quiet slot 0", bsv(), 0);
    feed(32 * 5);
    check("R8 slot 5 not own", own_frame, 0);
    feed(32);
    check("R8 slot 6 own", own_frame, 1);
    check("R9 own slot bs", bsv(), 7);
    msg_rx = 1'b1; #1;
    check("R9 message bs", bsv(), 5);
    msg_rx = 1'b0; #1;
    feed(32);
    check("R8 slot 7 own", own_frame, 1);
    feed(32);
    check("R8 slot 8 not own", own_frame, 0);
    check("R9 bs after own frame", bsv(), 0);
    feed(32 * 8);
    check("R9 sync slot bs", bsv(), 7);
    pulse_pre();
    check("R10 pre_det in rx", mode, 2);
    check("R10 slot unchanged", slot, 16);
    feed(32);
    self_frame = 3'd0; #1;
    check("R8 frame 0 at slot 0", own_frame, 1);
    feed(32);
    check("R8 frame 0 at slot 1", own_frame, 1);
    feed(32);
    check("R8 frame 0 at slot 2", own_frame, 0);
    rst = 1'b1; tick(); rst = 1'b0;
    check("R11 reset from rx", mode, 0);
    check("R11 bs after reset", bsv(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_wait_ignore();
    t_pre_expire();
    t_pre_tie();
    t_slots_sync();
    t_own_frame();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule